// File: doc/BRIEF.md
# Double-Buffered PWM Compare Unit

This block keeps the compare threshold of one PWM generator channel and watches a down-counting period counter that lives outside it. Whenever the counter equals the active threshold on an enabled channel, the unit raises a single-clock match strobe. Waveform generation logic, an interrupt source or an ADC trigger can take that strobe. A threshold that exceeds the period (load) value never produces a strobe.

Software never writes the active threshold directly. A bus write lands in a staging register, and its value moves into the active register only at a counter-zero event, so a new threshold never takes effect in the middle of a period. The unit has two commit policies. In immediate policy the staged value moves at the next zero. In synchronous policy it moves only at a zero that follows a global update request. That request is held until a zero consumes it, which lets several channels switch thresholds at the same boundary. A second write before a commit replaces the staged value, so the earlier value never takes effect. Reads return the staged value.

Top module: `pwm_cmp_unit`

## Requirements
- R1: After reset the read value, the staged value and the active threshold are all zero, and match_pulse is low.
- R2: With enable high, match_pulse is high in the clock after a cycle in which cnt equals the active threshold, and it stays high for that one clock only.
- R3: While the active threshold is greater than load, match_pulse stays low even if cnt equals the threshold.
- R4: With upd_mode = 0 (immediate), a staged value becomes the active threshold at the first counter-zero event (enable high and cnt = 0) after the write, and the active threshold changes at no other time.
- R5: With upd_mode = 1 (synchronous), a staged value is committed only at a counter-zero event that sees a held update request. A sync_req pulse is held until the next counter-zero event and is cleared by it. A request raised in the same cycle as a zero is not consumed by that zero and waits for the next one.
- R6: A second write before the commit replaces the staged value, and the earlier value never becomes active.
- R7: rd_data returns the staged value in bits 15:0 from the clock after the write. Bits 31:16 read as zero, and write data in bits 31:16 has no effect.
- R8: With enable low, match_pulse stays low and counter zeros commit nothing. Writes are still staged.
- R9: If a write arrives in the same cycle as a committing zero, the value staged before that write is the one committed, and the new value stays staged for a later commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Channel enable |
| upd_mode | input | 1 | Commit policy: 0 immediate, 1 synchronous |
| sync_req | input | 1 | Global synchronous-update request pulse |
| wr_en | input | 1 | Bus write strobe for the threshold register |
| wr_data | input | BUS_W (32) | Bus write data; only the low CMP_W bits are kept |
| rd_data | output | BUS_W (32) | Staged threshold, zero-extended |
| cnt | input | CMP_W (16) | Current value of the down-counter |
| load | input | CMP_W (16) | Period (reload) value of the counter |
| match_pulse | output | 1 | Registered one-clock strobe on a threshold match |

## Verification
The bench builds the block with its default widths: a 16-bit threshold behind a 32-bit bus word. This puts the full threshold range in reach. With it, a write of 16'hFFFF or of a value just above load tests the over-period rule, and set upper bus bits test the masking on readback. Load values of only a few counts keep the periods short. Many zero events, commits and races between writes, requests and zeros therefore fit into a short run. A random phase mixes both policies, the enable and stray requests.

// File: rtl/pwm_cmp_pkg.sv
// Shared types for the PWM compare unit.
// Assumes: nothing beyond the standard language.
package pwm_cmp_pkg;

    // Commit policy for a staged threshold.
    typedef enum logic {
        UPD_IMMEDIATE = 1'b0,
        UPD_SYNC      = 1'b1
    } upd_mode_e;

endpackage

// File: rtl/cmp_stage.sv
// Staging side of the compare register: holds the last written value,
// a flag that marks it as not yet committed, and the held global update request.
// Assumes: commit is produced by cmp_active and only at a zero event.
module cmp_stage #(
    parameter int CMP_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CMP_W-1:0] wr_val,
    input  logic             sync_req,
    input  logic             zero_evt,
    input  logic             commit,
    output logic [CMP_W-1:0] stage_q,
    output logic             stage_vld,
    output logic             sync_held
);

    // Staged value: the newest write always replaces the older one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else if (wr_en) begin
            stage_q <= wr_val;
        end
    end

    // Pending flag: a write sets it, and a commit clears it unless a write arrives in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_vld <= 1'b0;
        end else if (wr_en) begin
            stage_vld <= 1'b1;
        end else if (commit) begin
            stage_vld <= 1'b0;
        end
    end

    // Update request: held until a zero consumes it; a request raised at a zero survives it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_held <= 1'b0;
        end else if (sync_req) begin
            sync_held <= 1'b1;
        end else if (zero_evt) begin
            sync_held <= 1'b0;
        end
    end

endmodule

// File: rtl/cmp_active.sv
// Active threshold register and the commit decision for the two policies.
// Assumes: zero_evt is already gated with the channel enable.
module cmp_active
    import pwm_cmp_pkg::*;
#(
    parameter int CMP_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             zero_evt,
    input  upd_mode_e        mode,
    input  logic             stage_vld,
    input  logic             sync_held,
    input  logic [CMP_W-1:0] stage_q,
    output logic             commit,
    output logic [CMP_W-1:0] act_q
);

    logic policy_ok;

    // Policy gate: immediate always allows a commit, synchronous needs a held request.
    always_comb begin
        unique case (mode)
            UPD_IMMEDIATE: policy_ok = 1'b1;
            UPD_SYNC:      policy_ok = sync_held;
            default:       policy_ok = 1'b0;
        endcase
    end

    assign commit = zero_evt && stage_vld && policy_ok;

    // Active threshold: loads the staged value only on a commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q <= '0;
        end else if (commit) begin
            act_q <= stage_q;
        end
    end

endmodule

// File: rtl/cmp_match.sv
// Match detector: compares the counter with the active threshold and
// registers a one-clock strobe; suppressed when the threshold exceeds the period.
// Assumes: the counter moves every enabled cycle, so a match lasts one cycle.
module cmp_match #(
    parameter int CMP_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [CMP_W-1:0] cnt,
    input  logic [CMP_W-1:0] load,
    input  logic [CMP_W-1:0] act_q,
    output logic             match_pulse
);

    logic in_range;
    logic hit;

    assign in_range = (act_q <= load);
    assign hit      = enable && in_range && (cnt == act_q);

    // Output strobe register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            match_pulse <= 1'b0;
        end else begin
            match_pulse <= hit;
        end
    end

endmodule

// File: rtl/pwm_cmp_unit.sv
// Top of the double-buffered PWM compare unit: stages bus writes, commits
// them at counter-zero events under the selected policy and strobes on a match.
// Assumes: cnt counts down from load to zero outside this block; BUS_W >= CMP_W.
module pwm_cmp_unit
    import pwm_cmp_pkg::*;
#(
    parameter int CMP_W = 16,
    parameter int BUS_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             upd_mode,
    input  logic             sync_req,
    input  logic             wr_en,
    input  logic [BUS_W-1:0] wr_data,
    output logic [BUS_W-1:0] rd_data,
    input  logic [CMP_W-1:0] cnt,
    input  logic [CMP_W-1:0] load,
    output logic             match_pulse
);

    localparam int PAD_W = BUS_W - CMP_W;

    logic [CMP_W-1:0] stage_q;
    logic [CMP_W-1:0] act_q;
    logic             stage_vld;
    logic             sync_held;
    logic             commit;
    logic             zero_evt;
    upd_mode_e        mode;

    assign zero_evt = enable && (cnt == '0);
    assign mode     = upd_mode_e'(upd_mode);

    cmp_stage #(.CMP_W(CMP_W)) u_stage (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_val    (wr_data[CMP_W-1:0]),
        .sync_req  (sync_req),
        .zero_evt  (zero_evt),
        .commit    (commit),
        .stage_q   (stage_q),
        .stage_vld (stage_vld),
        .sync_held (sync_held)
    );

    cmp_active #(.CMP_W(CMP_W)) u_active (
        .clk       (clk),
        .rst_n     (rst_n),
        .zero_evt  (zero_evt),
        .mode      (mode),
        .stage_vld (stage_vld),
        .sync_held (sync_held),
        .stage_q   (stage_q),
        .commit    (commit),
        .act_q     (act_q)
    );

    cmp_match #(.CMP_W(CMP_W)) u_match (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable      (enable),
        .cnt         (cnt),
        .load        (load),
        .act_q       (act_q),
        .match_pulse (match_pulse)
    );

    // Readback path: the staged value, zero-extended to the bus width.
    generate
        if (PAD_W > 0) begin : g_pad
            logic unused_hi_bits;
            assign unused_hi_bits = ^wr_data[BUS_W-1:CMP_W];
            assign rd_data        = {{PAD_W{1'b0}}, stage_q};
        end else begin : g_nopad
            assign rd_data = stage_q;
        end
    endgenerate

endmodule

// File: rtl/pwm_cmp_unit_chk.sv
// Property checker for pwm_cmp_unit, attached by bind.
// Assumes: it sees the internal active threshold and held request of the top.
module pwm_cmp_unit_chk #(
    parameter int CMP_W = 16,
    parameter int BUS_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             enable,
    input logic             upd_mode,
    input logic             wr_en,
    input logic [BUS_W-1:0] wr_data,
    input logic [BUS_W-1:0] rd_data,
    input logic [CMP_W-1:0] cnt,
    input logic [CMP_W-1:0] load,
    input logic             match_pulse,
    input logic [CMP_W-1:0] act_q,
    input logic             sync_held
);

    // R2: a strobe follows a cycle where the counter equalled the threshold.
    p_pulse_on_equal_r2: assert property (@(posedge clk) disable iff (!rst_n)
        match_pulse |-> $past(cnt) == $past(act_q));

    // R3: no strobe while the threshold exceeded the period.
    p_no_pulse_over_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        match_pulse |-> $past(act_q) <= $past(load));

    // R4: the active threshold only moves at a counter zero.
    p_act_moves_at_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(act_q) |-> ($past(enable) && $past(cnt) == '0));

    // R5: in synchronous policy, no move without a held request.
    p_sync_needs_request_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(upd_mode) && !$past(sync_held)) |-> $stable(act_q));

    // R7: readback shows the low bits of the last write.
    p_read_follows_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> rd_data[CMP_W-1:0] == $past(wr_data[CMP_W-1:0]));

    // R8: no strobe from a disabled cycle.
    p_no_pulse_disabled_r8: assert property (@(posedge clk) disable iff (!rst_n)
        match_pulse |-> $past(enable));

endmodule

bind pwm_cmp_unit pwm_cmp_unit_chk #(.CMP_W(CMP_W), .BUS_W(BUS_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .enable      (enable),
    .upd_mode    (upd_mode),
    .wr_en       (wr_en),
    .wr_data     (wr_data),
    .rd_data     (rd_data),
    .cnt         (cnt),
    .load        (load),
    .match_pulse (match_pulse),
    .act_q       (act_q),
    .sync_held   (sync_held)
);

// File: tb/test_pwm_cmp_unit.sv
`timescale 1ns/1ps
module test_pwm_cmp_unit;

    localparam int CMP_W = 16;
    localparam int BUS_W = 32;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             enable = 1'b0;
    logic             upd_mode = 1'b0;
    logic             sync_req = 1'b0;
    logic             wr_en = 1'b0;
    logic [BUS_W-1:0] wr_data = '0;
    logic [BUS_W-1:0] rd_data;
    logic [CMP_W-1:0] cnt = '0;
    logic [CMP_W-1:0] load = '0;
    logic             match_pulse;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Reference state kept from the requirements.
    logic [CMP_W-1:0] m_stage = '0;
    logic             m_vld   = 1'b0;
    logic             m_sync  = 1'b0;
    logic [CMP_W-1:0] m_act   = '0;
    logic             m_match = 1'b0;

    always #2.5 clk = ~clk;

    pwm_cmp_unit #(.CMP_W(CMP_W), .BUS_W(BUS_W)) i_pwm_cmp_unit (
        .clk(clk), .rst_n(rst_n), .enable(enable), .upd_mode(upd_mode),
        .sync_req(sync_req), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .cnt(cnt), .load(load), .match_pulse(match_pulse)
    );

    function automatic logic next_match(logic en, logic [CMP_W-1:0] c,
                                        logic [CMP_W-1:0] ld, logic [CMP_W-1:0] a);
        return en && (a <= ld) && (c == a);
    endfunction

    function automatic logic [CMP_W-1:0] next_cnt(logic [CMP_W-1:0] c, logic [CMP_W-1:0] ld);
        return (c == '0) ? ld : c - 1'b1;
    endfunction

    task automatic check(string tag, string what, logic [BUS_W-1:0] act, logic [BUS_W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // One clock: advance the reference from pre-edge inputs, then compare.
    task automatic step(string tag);
        logic zero, commit;
        logic [CMP_W-1:0] a_n;
        zero   = enable && (cnt == '0);
        commit = zero && m_vld && (!upd_mode || m_sync);
        a_n    = commit ? m_stage : m_act;
        m_match = next_match(enable, cnt, load, m_act);
        m_vld   = wr_en ? 1'b1 : (commit ? 1'b0 : m_vld);
        m_sync  = sync_req ? 1'b1 : (zero ? 1'b0 : m_sync);
        if (wr_en) m_stage = wr_data[CMP_W-1:0];
        m_act = a_n;
        @(posedge clk);
        #1;
        check(tag, "match_pulse", {31'd0, match_pulse}, {31'd0, m_match});
        check("R7", "rd_data", rd_data, {16'd0, m_stage});
    endtask

    // Clock with a free-running counter; single-cycle strobes are dropped after it.
    task automatic tick(string tag);
        step(tag);
        cnt      = next_cnt(cnt, load);
        wr_en    = 1'b0;
        sync_req = 1'b0;
    endtask

    task automatic run(int n, string tag);
        for (int i = 0; i < n; i++) tick(tag);
    endtask

    task automatic to_zero(string tag);
        while (cnt != '0) tick(tag);
    endtask

    task automatic write(logic [BUS_W-1:0] v);
        wr_en   = 1'b1;
        wr_data = v;
    endtask

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog all actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int pulses;
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        check("R1", "rd_data after reset", rd_data, '0);
        check("R1", "match_pulse after reset", {31'd0, match_pulse}, '0);

        // R1: reset threshold of zero strobes once per period at the counter zero.
        load = 16'd7; cnt = 16'd7; enable = 1'b1;
        pulses = 0;
        for (int i = 0; i < 16; i++) begin tick("R1"); pulses += match_pulse; end
        check("R1", "pulses with zero threshold", pulses, 2);

        // R4: immediate commit at the next zero.
        run(2, "R4");
        write(32'd3);
        tick("R4");
        check("R4", "pending before zero", rd_data, 32'd3);
        run(20, "R4");

        // R6: rewrite before commit discards the first value.
        run(3, "R6");
        write(32'd5); tick("R6");
        write(32'd2); tick("R6");
        pulses = 0;
        for (int i = 0; i < 24; i++) begin
            tick("R6");
            if (match_pulse && m_act == 16'd5) pulses++;
        end
        check("R6", "strobes at discarded value", pulses, 0);

        // R5: synchronous policy waits for a held request.
        upd_mode = 1'b1;
        write(32'd4); tick("R5");
        run(20, "R5");
        check("R5", "threshold still old", {16'd0, m_act}, 32'd2);
        to_zero("R5");
        sync_req = 1'b1;              // request coincident with a zero
        tick("R5");
        run(3, "R5");
        check("R5", "coincident request not consumed", {16'd0, m_act}, 32'd2);
        run(10, "R5");
        check("R5", "committed at following zero", {16'd0, m_act}, 32'd4);
        sync_req = 1'b1; tick("R5");  // stray request with nothing staged
        run(10, "R5");

        // R3: threshold above load never strobes, even with an equal counter.
        upd_mode = 1'b0;
        write(32'hABCD_FFFF);
        tick("R7");
        check("R7", "upper bits masked", rd_data, 32'h0000_FFFF);
        run(20, "R3");
        cnt = 16'hFFFF; step("R3");
        cnt = 16'd6;
        write(32'd9); run(20, "R3");
        cnt = 16'd9; step("R3");
        cnt = 16'd7;
        load = 16'd9; run(25, "R3");

        // R8: disabled channel neither strobes nor commits.
        load = 16'd7; cnt = 16'd7;
        write(32'd1); tick("R8");
        enable = 1'b0;
        pulses = 0;
        for (int i = 0; i < 20; i++) begin tick("R8"); pulses += match_pulse; end
        check("R8", "no strobes while disabled", pulses, 0);
        check("R8", "threshold unchanged", {16'd0, m_act}, 32'd9);
        enable = 1'b1;
        run(20, "R8");

        // R9: write in the same cycle as a committing zero.
        write(32'd6); tick("R9");
        to_zero("R9");
        write(32'd3); tick("R9");
        check("R9", "older staged value committed", {16'd0, m_act}, 32'd6);
        check("R9", "new value staged", rd_data, 32'd3);
        run(20, "R9");
        check("R9", "new value committed later", {16'd0, m_act}, 32'd3);

        // R2: random mix of writes, policies, requests and enable.
        for (int blk = 0; blk < 8; blk++) begin
            load = 16'($urandom_range(3, 12));
            cnt  = load;
            for (int i = 0; i < 120; i++) begin
                if ($urandom_range(0, 9) == 0) write(32'($urandom_range(0, 14)) | ($urandom << 16));
                if ($urandom_range(0, 14) == 0) sync_req = 1'b1;
                if ($urandom_range(0, 29) == 0) upd_mode = ~upd_mode;
                enable = ($urandom_range(0, 19) != 0);
                tick("R2");
            end
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule